// File: doc/BRIEF.md
# Privileged Status and Interrupt Control Register File

This block holds the machine-level status, interrupt and trap-setup registers of a processor hart and applies a write-legalisation mask to every write. Software issues an access with a 12-bit register address, write data and a write strobe. Writes take effect at the next rising clock edge. The read port is combinational and always returns the legalised content of the addressed register.

The supervisor-level status, pending and enable registers have no storage of their own. They are filtered windows onto the machine registers. The pending and enable windows are filtered by the interrupt delegation register. The status window is filtered by a fixed set of supervisor-visible fields. The status summary-dirty bit is not stored: it is derived on every read from the floating-point and extension state fields.

An address that the block does not implement raises an illegal-access flag. Such an access reads as zero and is not written. The decision on what to do with the flag belongs to the surrounding pipeline.

Top module: `priv_csr_file`

## Requirements
- R1: After reset every implemented register reads as zero.
- R2: In the machine pending register (address 0x344) only bit 1 (supervisor software) and bit 5 (supervisor timer) are writable; all other bits read as zero.
- R3: The machine enable register (0x304) keeps only bits 1, 3, 5, 7, 9 and 12 of a write; all other bits read as zero.
- R4: The interrupt delegation register (0x303) keeps only bits 1, 5, 9 and 12 of a write.
- R5: A write to machine status (0x300) changes only bits 1, 3, 5, 7, 8, 14:13, 17 and 18, plus the privilege field in bits 12:11 under R6. All other status bits read as zero.
- R6: The status privilege field in bits 12:11 is updated only when the written value is 0, 1 or 3. A written value of 2 leaves the field unchanged, and the other fields in the same write still update.
- R7: The status summary bit in bit XLEN-1 reads as 1 exactly when bits 14:13 or bits 16:15 are both 1. This applies to both the machine status read and the supervisor status read.
- R8: Supervisor pending (0x144) and supervisor enable (0x104) read as the machine register ANDed with the delegation register. A write to either one changes only the delegated bits of the machine register, and the R2 and R3 masks still apply.
- R9: Supervisor status (0x100) reads only bits 1, 5, 8, 14:13, 16:15 and 18 of machine status, plus the summary bit. A write to it changes only those bits of machine status. Bits 16:15 are read-only zero.
- R10: Writes to the machine trap vector (0x305) and the supervisor trap vector (0x105) clear the lowest two bits.
- R11: The two counter-enable registers (0x320 and 0x321) keep only bits 2:0.
- R12: An access to any other address drives the illegal flag high and reads as zero, and a write to such an address changes no register. An implemented address drives the flag low.
- R13: The scratch registers (0x340 and 0x140) hold the full written word. The exception delegation register (0x302) keeps only the bits set in parameter EXC_DELEG_MASK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register address for both read and write |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Legalised content of the addressed register |
| csr_illegal | output | 1 | Address is not implemented |

## Verification
A bad mask or a corrupted field in stored state is not hidden for long. It appears on the read port in the first cycle after the offending write, once the bench addresses the affected register. The supervisor windows add a second path: a delegation fault appears both as a wrong supervisor read and as a wrong machine read after a supervisor write. The summary bit is derived and not stored, so it is wrong in the same cycle that the field it depends on is wrong.

// File: rtl/priv_csr_file.sv
module priv_csr_file #(
  parameter int          XLEN           = 64,
  parameter logic [31:0] EXC_DELEG_MASK = 32'h0000_0BFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal
);

  localparam logic [11:0] A_SSTATUS  = 12'h100;
  localparam logic [11:0] A_SIE      = 12'h104;
  localparam logic [11:0] A_STVEC    = 12'h105;
  localparam logic [11:0] A_SSCRATCH = 12'h140;
  localparam logic [11:0] A_SIP      = 12'h144;
  localparam logic [11:0] A_MSTATUS  = 12'h300;
  localparam logic [11:0] A_EDELEG   = 12'h302;
  localparam logic [11:0] A_IDELEG   = 12'h303;
  localparam logic [11:0] A_MIE      = 12'h304;
  localparam logic [11:0] A_MTVEC    = 12'h305;
  localparam logic [11:0] A_UCEN     = 12'h320;
  localparam logic [11:0] A_SCEN     = 12'h321;
  localparam logic [11:0] A_MSCRATCH = 12'h340;
  localparam logic [11:0] A_MIP      = 12'h344;

  localparam logic [XLEN-1:0] IRQ_DELEGABLE = XLEN'(32'h0000_1222);
  localparam logic [XLEN-1:0] IRQ_ALL       = XLEN'(32'h0000_12AA);
  localparam logic [XLEN-1:0] IRQ_SW_PEND   = XLEN'(32'h0000_0022);
  localparam logic [XLEN-1:0] ST_WMASK      = XLEN'(32'h0006_61AA);
  localparam logic [XLEN-1:0] ST_PRIVMASK   = XLEN'(32'h0000_1800);
  localparam logic [XLEN-1:0] ST_SVIEW      = XLEN'(32'h0005_E122);
  localparam logic [XLEN-1:0] EDELEG_MASK   = XLEN'(EXC_DELEG_MASK);
  localparam logic [XLEN-1:0] TVEC_MASK     = ~XLEN'(2'b11);
  localparam logic [XLEN-1:0] SUMMARY_BIT   = XLEN'(1) << (XLEN-1);

  logic [XLEN-1:0] mstatus_q, mip_q, mie_q, mideleg_q, medeleg_q;
  logic [XLEN-1:0] mtvec_q, stvec_q, mscratch_q, sscratch_q;
  logic [2:0]      ucen_q, scen_q;

  function automatic logic [XLEN-1:0] status_merge(input logic [XLEN-1:0] cur,
                                                   input logic [XLEN-1:0] val);
    logic [XLEN-1:0] m;
    m = ST_WMASK;
    if (val[12:11] != 2'b10) m = m | ST_PRIVMASK;
    return (cur & ~m) | (val & m);
  endfunction

  logic            dirty;
  logic [XLEN-1:0] summary;
  assign dirty   = (&mstatus_q[14:13]) | (&mstatus_q[16:15]);
  assign summary = dirty ? SUMMARY_BIT : '0;

  logic [XLEN-1:0] rd;
  logic            hit;

  always_comb begin
    hit = 1'b1;
    rd  = '0;
    case (csr_addr)
      A_SSTATUS:  rd = (mstatus_q & ST_SVIEW) | summary;
      A_SIE:      rd = mie_q & mideleg_q;
      A_STVEC:    rd = stvec_q;
      A_SSCRATCH: rd = sscratch_q;
      A_SIP:      rd = mip_q & mideleg_q;
      A_MSTATUS:  rd = mstatus_q | summary;
      A_EDELEG:   rd = medeleg_q;
      A_IDELEG:   rd = mideleg_q;
      A_MIE:      rd = mie_q;
      A_MTVEC:    rd = mtvec_q;
      A_UCEN:     rd = XLEN'(ucen_q);
      A_SCEN:     rd = XLEN'(scen_q);
      A_MSCRATCH: rd = mscratch_q;
      A_MIP:      rd = mip_q;
      default:    hit = 1'b0;
    endcase
  end

  assign csr_rdata   = rd;
  assign csr_illegal = ~hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mstatus_q  <= '0;
      mip_q      <= '0;
      mie_q      <= '0;
      mideleg_q  <= '0;
      medeleg_q  <= '0;
      mtvec_q    <= '0;
      stvec_q    <= '0;
      mscratch_q <= '0;
      sscratch_q <= '0;
      ucen_q     <= '0;
      scen_q     <= '0;
    end else if (csr_we) begin
      case (csr_addr)
        A_SSTATUS:  mstatus_q  <= status_merge(mstatus_q,
                                    (mstatus_q & ~ST_SVIEW) | (csr_wdata & ST_SVIEW));
        A_SIE:      mie_q      <= ((mie_q & ~mideleg_q) | (csr_wdata & mideleg_q)) & IRQ_ALL;
        A_STVEC:    stvec_q    <= csr_wdata & TVEC_MASK;
        A_SSCRATCH: sscratch_q <= csr_wdata;
        A_SIP:      mip_q      <= ((mip_q & ~mideleg_q) | (csr_wdata & mideleg_q)) & IRQ_SW_PEND;
        A_MSTATUS:  mstatus_q  <= status_merge(mstatus_q, csr_wdata);
        A_EDELEG:   medeleg_q  <= csr_wdata & EDELEG_MASK;
        A_IDELEG:   mideleg_q  <= csr_wdata & IRQ_DELEGABLE;
        A_MIE:      mie_q      <= csr_wdata & IRQ_ALL;
        A_MTVEC:    mtvec_q    <= csr_wdata & TVEC_MASK;
        A_UCEN:     ucen_q     <= csr_wdata[2:0];
        A_SCEN:     scen_q     <= csr_wdata[2:0];
        A_MSCRATCH: mscratch_q <= csr_wdata;
        A_MIP:      mip_q      <= (mip_q & ~IRQ_SW_PEND) | (csr_wdata & IRQ_SW_PEND);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/priv_csr_file_chk.sv
module priv_csr_file_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_we,
  input logic            csr_illegal,
  input logic [XLEN-1:0] csr_rdata,
  input logic [XLEN-1:0] mip_q,
  input logic [XLEN-1:0] mideleg_q,
  input logic [XLEN-1:0] mstatus_q,
  input logic [XLEN-1:0] mtvec_q,
  input logic [XLEN-1:0] stvec_q,
  input logic [XLEN-1:0] mscratch_q
);

  AST_PEND_ONLY_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    (mip_q & ~XLEN'(32'h22)) == '0); // R2

  AST_DELEG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mideleg_q & ~XLEN'(32'h1222)) == '0); // R4

  AST_PRIV_FIELD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mstatus_q[12:11] != 2'b10); // R6

  AST_TVEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mtvec_q[1:0] == 2'b00) && (stvec_q[1:0] == 2'b00)); // R10

  AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0)); // R12

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_illegal) |=> ($stable(mstatus_q) && $stable(mscratch_q) && $stable(mip_q))); // R12

endmodule

bind priv_csr_file priv_csr_file_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csr_we     (csr_we),
  .csr_illegal(csr_illegal),
  .csr_rdata  (csr_rdata),
  .mip_q      (mip_q),
  .mideleg_q  (mideleg_q),
  .mstatus_q  (mstatus_q),
  .mtvec_q    (mtvec_q),
  .stvec_q    (stvec_q),
  .mscratch_q (mscratch_q)
);

// File: tb/priv_csr_file_test.sv
module priv_csr_file_test;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SD   = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        csr_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  priv_csr_file #(.XLEN(64)) uut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal)
  );

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [63:0] exp, input string tag);
    @(negedge clk);
    csr_we = 1'b0; csr_addr = a;
    #1;
    checks++;
    if (csr_rdata !== exp || csr_illegal !== 1'b0) begin
      errors++;
      $display("FAIL %s addr %h: got %h ill %b, expected %h ill 0", tag, a, csr_rdata, csr_illegal, exp);
    end
  endtask

  task automatic t_reset();
    rd(12'h300, 64'h0, "R1 mstatus");
    rd(12'h304, 64'h0, "R1 enable");
    rd(12'h344, 64'h0, "R1 pending");
    rd(12'h305, 64'h0, "R1 mtvec");
    rd(12'h340, 64'h0, "R1 mscratch");
    rd(12'h320, 64'h0, "R1 ucen");
  endtask

  task automatic t_pending();
    wr(12'h344, ONES);
    rd(12'h344, 64'h22, "R2 pending ones");
    wr(12'h344, 64'h20);
    rd(12'h344, 64'h20, "R2 pending timer only");
    wr(12'h344, 64'h0);
  endtask

  task automatic t_enable();
    wr(12'h304, ONES);
    rd(12'h304, 64'h12AA, "R3 enable ones");
  endtask

  task automatic t_deleg();
    wr(12'h303, ONES);
    rd(12'h303, 64'h1222, "R4 ideleg ones");
  endtask

  task automatic t_status();
    wr(12'h300, ONES);
    rd(12'h300, SD | 64'h679AA, "R5 status ones");
    wr(12'h300, 64'h0);
    rd(12'h300, 64'h0, "R5 status clear");
  endtask

  task automatic t_priv();
    wr(12'h300, 64'h800);
    rd(12'h300, 64'h800, "R6 priv 1 accepted");
    wr(12'h300, 64'h1008);
    rd(12'h300, 64'h808, "R6 priv 2 rejected");
    wr(12'h300, 64'h0);
  endtask

  task automatic t_summary();
    wr(12'h300, 64'h2000);
    rd(12'h300, 64'h2000, "R7 fs partial");
    wr(12'h300, 64'h6000);
    rd(12'h300, SD | 64'h6000, "R7 fs dirty");
    rd(12'h100, SD | 64'h6000, "R7 sview dirty");
    wr(12'h300, 64'h0);
  endtask

  task automatic t_sview();
    wr(12'h303, 64'h22);
    wr(12'h304, ONES);
    rd(12'h104, 64'h22, "R8 sie read");
    wr(12'h104, 64'h0);
    rd(12'h304, 64'h1288, "R8 sie write");
    wr(12'h344, 64'h0);
    wr(12'h144, ONES);
    rd(12'h144, 64'h22, "R8 sip read");
    wr(12'h303, 64'h2);
    wr(12'h144, 64'h0);
    rd(12'h344, 64'h20, "R8 sip undelegated kept");
    rd(12'h144, 64'h0, "R8 sip read masked");
  endtask

  task automatic t_sstatus();
    wr(12'h300, 64'h808);
    wr(12'h100, ONES);
    rd(12'h300, SD | 64'h4692A, "R9 sstatus write");
    rd(12'h100, SD | 64'h46122, "R9 sstatus read");
    wr(12'h100, 64'h0);
    rd(12'h300, 64'h808, "R9 machine fields kept");
    rd(12'h100, 64'h0, "R9 sstatus cleared");
  endtask

  task automatic t_tvec();
    wr(12'h305, 64'h1234_5678_9ABC_DEF3);
    rd(12'h305, 64'h1234_5678_9ABC_DEF0, "R10 mtvec");
    wr(12'h105, 64'h7);
    rd(12'h105, 64'h4, "R10 stvec");
  endtask

  task automatic t_cen();
    wr(12'h320, ONES);
    rd(12'h320, 64'h7, "R11 ucen");
    wr(12'h321, 64'h5A);
    rd(12'h321, 64'h2, "R11 scen");
  endtask

  task automatic t_scratch();
    wr(12'h340, 64'hDEAD_BEEF_0123_4567);
    rd(12'h340, 64'hDEAD_BEEF_0123_4567, "R13 mscratch");
    wr(12'h140, 64'hA5A5_5A5A_F0F0_0F0F);
    rd(12'h140, 64'hA5A5_5A5A_F0F0_0F0F, "R13 sscratch");
    wr(12'h302, ONES);
    rd(12'h302, 64'hBFF, "R13 edeleg mask");
  endtask

  task automatic t_illegal();
    @(negedge clk);
    csr_addr = 12'h7FF; csr_we = 1'b0;
    #1;
    checks++;
    if (csr_illegal !== 1'b1 || csr_rdata !== 64'h0) begin
      errors++;
      $display("FAIL R12 unimplemented read: got ill %b data %h, expected ill 1 data 0", csr_illegal, csr_rdata);
    end
    wr(12'h341, ONES);
    wr(12'h7FF, ONES);
    rd(12'h340, 64'hDEAD_BEEF_0123_4567, "R12 mscratch untouched");
    rd(12'h300, 64'h808, "R12 mstatus untouched");
    rd(12'h344, 64'h20, "R12 pending untouched");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pending();
    t_enable();
    t_deleg();
    t_status();
    t_priv();
    t_summary();
    t_sview();
    t_sstatus();
    t_tvec();
    t_cen();
    t_scratch();
    t_illegal();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule